// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker follows a chain of 64-bit transfer descriptors in system memory and hands each one to a downstream data mover. Software loads the table's byte address on `table_base` and pulses `start`. The walker then reads one descriptor at a time through a single-beat memory read port and decodes it. If the descriptor asks for a data transfer, the walker presents the address and byte count to the mover. It holds that request until the mover reports completion, and only then reads the next descriptor, which sits 8 bytes further on.

Each descriptor word has three fields. The 32-bit data address is in bits 63:32. The byte count is in bits 31:16, and a count of zero stands for 65536 bytes. The attribute bits are in 15:0. Attribute bit 0 marks the descriptor valid and bit 1 marks it as the last in the chain. Bits 5:4 carry an action code, where 2'b10 requests a data transfer. The remaining attribute bits are ignored.

The walk stops in one of two ways. After the last descriptor's work completes, the walker emits a one-cycle `done` pulse. If it meets a descriptor whose valid bit is clear, it stops, raises `adma_err` and reports that descriptor's address on `err_addr`.

The controller has five states:
- ST_IDLE waits for `start` and takes the transition to ST_FETCH.
- ST_FETCH issues one read and always takes the transition to ST_WAIT.
- ST_WAIT stays until `rd_valid`, then takes the transition to ST_DECODE.
- ST_DECODE has four transitions:
  - invalid descriptor: to ST_IDLE, flagging an error;
  - transfer descriptor: to ST_MOVE;
  - non-transfer descriptor marked last: to ST_IDLE with done;
  - non-transfer descriptor not marked last: to ST_FETCH with the pointer advanced.
- ST_MOVE holds the mover request. On `mv_done` it goes to ST_IDLE with done if the descriptor is marked last, and otherwise to ST_FETCH with the pointer advanced.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `busy`, `done`, `adma_err`, `rd_req` and `mv_req` are all low.
- R2: A `start` accepted while idle latches `table_base`. The first descriptor read uses that address, and each following read uses the previous read address plus 8. `busy` is high from the cycle after `start`.
- R3: For a transfer descriptor (bit 0 = 1, bits 5:4 = 2'b10), `mv_addr` equals descriptor bits 63:32 and `mv_len` equals bits 31:16.
- R4: A byte count field of zero gives `mv_len` = 65536. `mv_len` is never zero.
- R5: No descriptor read is issued while a mover request is outstanding. The next read follows `mv_done`.
- R6: After the work of a descriptor with bit 1 set completes, `done` pulses high for exactly one cycle, `busy` drops in that same cycle, and no further reads follow.
- R7: A descriptor with bit 0 clear issues no move. The walker stops with `adma_err` high, `err_addr` set to that descriptor's address, and no `done` pulse.
- R8: A valid descriptor whose action code is not 2'b10 issues no move. The walk then ends or continues according to its bit 1.
- R9: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R10: `adma_err` stays high until the next accepted `start`, which clears it.
- R11: While `mv_req` is high and `mv_done` is low, `mv_req`, `mv_addr` and `mv_len` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; honoured only when idle |
| table_base | input | ADDR_W | Byte address of the first descriptor |
| rd_req | output | 1 | One-cycle descriptor read request |
| rd_addr | output | ADDR_W | Descriptor read address |
| rd_valid | input | 1 | Read data valid, one cycle |
| rd_data | input | 16+LEN_W+ADDR_W | Descriptor word |
| mv_req | output | 1 | Data move request, held until `mv_done` |
| mv_addr | output | ADDR_W | Data address for the move |
| mv_len | output | LEN_W+1 | Byte count for the move |
| mv_done | input | 1 | Move finished, one cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the chain ends normally |
| adma_err | output | 1 | Invalid descriptor met |
| err_addr | output | ADDR_W | Address of the invalid descriptor |

## Verification
The assertions assume the following about the environment:
- `rd_valid` arrives only while a read is pending;
- `mv_done` pulses only while `mv_req` is high;
- both pulses last a single cycle.

The bench's memory and mover models respond only to a request they have observed. They wait a latency of at least one cycle for reads and zero or more cycles for moves, drop the response after one cycle, and never respond twice to one request. This keeps the stimulus within those assumptions while still varying read and move latency across the sweep of chain lengths and invalid-descriptor positions.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DECODE,
        ST_MOVE
    } walk_state_e;

    localparam int ATTR_BITS = 16;
    localparam int VALID_BIT = 0;
    localparam int END_BIT   = 1;
    localparam int ACT_LO    = 4;
    localparam logic [1:0] ACT_MOVE = 2'b10;
endpackage

// File: rtl/sgw_decode.sv
module sgw_decode
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ATTR_BITS+LEN_W+ADDR_W-1:0] raw,
    output logic                              valid,
    output logic                              last,
    output logic                              xfer,
    output logic [ADDR_W-1:0]                 addr,
    output logic [LEN_W:0]                    len
);
    localparam int ADDR_LO = ATTR_BITS + LEN_W;

    logic [LEN_W-1:0] len_field;
    logic [1:0]       action;
    logic             unused_attr;

    assign len_field   = raw[ATTR_BITS +: LEN_W];
    assign action      = raw[ACT_LO +: 2];
    assign valid       = raw[VALID_BIT];
    assign last        = raw[END_BIT];
    assign xfer        = (action == ACT_MOVE);
    assign addr        = raw[ADDR_LO +: ADDR_W];
    assign unused_attr = ^{raw[ATTR_BITS-1:ACT_LO+2], raw[ACT_LO-1:END_BIT+1]};

    // a zero count field encodes the full 2**LEN_W bytes
    always_comb begin
        if (len_field == '0) begin
            len = {1'b1, {LEN_W{1'b0}}};
        end else begin
            len = {1'b0, len_field};
        end
    end
endmodule

// File: rtl/sgw_ptr.sv
module sgw_ptr #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              mark_err,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] err_addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (step) begin
            cur <= cur + STEP_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_addr <= '0;
        end else if (mark_err) begin
            err_addr <= cur;
        end
    end
endmodule

// File: rtl/sgw_fsm.sv
module sgw_fsm
    import sgw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_valid,
    input  logic mv_done,
    input  logic d_valid,
    input  logic d_last,
    input  logic d_xfer,
    output logic load_base,
    output logic step_ptr,
    output logic capture,
    output logic mark_err,
    output logic rd_req,
    output logic mv_req,
    output logic busy,
    output logic done,
    output logic err
);
    walk_state_e state_q, state_d;
    logic        finish;

    always_comb begin
        state_d   = state_q;
        load_base = 1'b0;
        step_ptr  = 1'b0;
        capture   = 1'b0;
        mark_err  = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load_base = 1'b1;
                    state_d   = ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    capture = 1'b1;
                    state_d = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (!d_valid) begin
                    mark_err = 1'b1;
                    state_d  = ST_IDLE;
                end else if (d_xfer) begin
                    state_d = ST_MOVE;
                end else if (d_last) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    step_ptr = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_MOVE: begin
                if (mv_done) begin
                    if (d_last) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        step_ptr = 1'b1;
                        state_d  = ST_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
            if (load_base) begin
                err <= 1'b0;
            end else if (mark_err) begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_req = (state_q == ST_FETCH);
        mv_req = (state_q == ST_MOVE);
        busy   = (state_q != ST_IDLE);
    end

    assert_no_read_while_moving_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> !rd_req);

    assert_err_stops_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mark_err |=> (err && !busy && !done));

    assert_err_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int STRIDE = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [ADDR_W-1:0]                 table_base,
    output logic                              rd_req,
    output logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              rd_valid,
    input  logic [ATTR_BITS+LEN_W+ADDR_W-1:0] rd_data,
    output logic                              mv_req,
    output logic [ADDR_W-1:0]                 mv_addr,
    output logic [LEN_W:0]                    mv_len,
    input  logic                              mv_done,
    output logic                              busy,
    output logic                              done,
    output logic                              adma_err,
    output logic [ADDR_W-1:0]                 err_addr
);
    localparam int DESC_W = ATTR_BITS + LEN_W + ADDR_W;

    logic [DESC_W-1:0] desc_q;
    logic              load_base, step_ptr, capture, mark_err;
    logic              d_valid, d_last, d_xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (capture) begin
            desc_q <= rd_data;
        end
    end

    sgw_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decode (
        .raw   (desc_q),
        .valid (d_valid),
        .last  (d_last),
        .xfer  (d_xfer),
        .addr  (mv_addr),
        .len   (mv_len)
    );

    sgw_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_base),
        .step     (step_ptr),
        .mark_err (mark_err),
        .base     (table_base),
        .cur      (rd_addr),
        .err_addr (err_addr)
    );

    sgw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_valid  (rd_valid),
        .mv_done   (mv_done),
        .d_valid   (d_valid),
        .d_last    (d_last),
        .d_xfer    (d_xfer),
        .load_base (load_base),
        .step_ptr  (step_ptr),
        .capture   (capture),
        .mark_err  (mark_err),
        .rd_req    (rd_req),
        .mv_req    (mv_req),
        .busy      (busy),
        .done      (done),
        .err       (adma_err)
    );

    assert_move_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_addr) && $stable(mv_len)));

    assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> ((mv_len != '0) && (mv_len <= {1'b1, {LEN_W{1'b0}}})));

    assert_done_ends_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mv_req && !rd_req));
endmodule

// File: tb/tb_sg_desc_walker.sv
`timescale 1ns/1ps
module tb_sg_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] table_base = '0;
    logic        rd_req, mv_req, busy, done, adma_err;
    logic [31:0] rd_addr, mv_addr, err_addr;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [16:0] mv_len;
    logic        mv_done = 1'b0;

    always #4 clk = ~clk;

    sg_desc_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
        .busy(busy), .done(done), .adma_err(adma_err), .err_addr(err_addr)
    );

    logic [63:0] mem [0:63];
    int rd_lat = 1;
    int mv_lat = 0;
    logic [31:0] rd_log [0:63];
    logic [31:0] mv_alog [0:63];
    logic [16:0] mv_llog [0:63];
    int n_rd, n_mv, n_done, n_overlap, n_unstable;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    function automatic logic [63:0] mk(bit v, bit e, logic [1:0] act, logic [15:0] len, logic [31:0] a);
        return {a, len, 10'b0, act, 2'b00, e, v};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory read model
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                logic [5:0] idx;
                idx = rd_addr[8:3];
                if (n_rd < 64) rd_log[n_rd] = rd_addr;
                n_rd++;
                repeat (rd_lat) @(negedge clk);
                rd_data  = mem[idx];
                rd_valid = 1'b1;
                @(negedge clk);
                rd_valid = 1'b0;
            end
        end
    end

    // data mover model
    initial begin
        forever begin
            @(negedge clk);
            if (mv_req) begin
                logic [31:0] a;
                logic [16:0] l;
                a = mv_addr;
                l = mv_len;
                if (n_mv < 64) begin
                    mv_alog[n_mv] = a;
                    mv_llog[n_mv] = l;
                end
                n_mv++;
                for (int k = 0; k < mv_lat; k++) begin
                    @(negedge clk);
                    if (!mv_req || mv_addr != a || mv_len != l) n_unstable++;
                end
                mv_done = 1'b1;
                @(negedge clk);
                mv_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done) n_done++;
            if (rd_req && mv_req) n_overlap++;
        end
    end

    task automatic run_chain(input logic [31:0] base, input int inject, input string mtag);
        logic [31:0] ea [0:63];
        logic [16:0] el [0:63];
        logic [31:0] eaddr;
        logic [63:0] d;
        int ne, nr, cyc;
        bit eerr, edone;
        n_rd = 0; n_mv = 0; n_done = 0; n_overlap = 0; n_unstable = 0;
        @(negedge clk);
        table_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        chk(adma_err == 1'b0, "R10", "err cleared by start", adma_err, 0);
        cyc = 0;
        while (busy && cyc < 5000) begin
            if (cyc == inject) begin
                table_base = 32'h8000_0000 + 40 * 8;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
        // expected walk from the requirements
        ne = 0; nr = 0; eerr = 0; edone = 0; eaddr = '0;
        for (int i = 0; i < 64; i++) begin
            d = mem[6'(base[8:3] + i)];
            nr++;
            if (!d[0]) begin
                eerr = 1;
                eaddr = base + 32'(8 * i);
                break;
            end
            if (d[5:4] == 2'b10) begin
                ea[ne] = d[63:32];
                el[ne] = (d[31:16] == 16'h0) ? 17'h10000 : {1'b0, d[31:16]};
                ne++;
            end
            if (d[1]) begin
                edone = 1;
                break;
            end
        end
        chk(n_rd == nr, "R2", "read count", n_rd, nr);
        for (int j = 0; j < nr && j < n_rd; j++)
            chk(rd_log[j] == base + 32'(8 * j), "R2", "read address", rd_log[j], base + 32'(8 * j));
        chk(n_mv == ne, mtag, "move count", n_mv, ne);
        for (int j = 0; j < ne && j < n_mv; j++) begin
            chk(mv_alog[j] == ea[j], "R3", "move address", mv_alog[j], ea[j]);
            chk(mv_llog[j] == el[j], (el[j] == 17'h10000) ? "R4" : "R3", "move length", mv_llog[j], el[j]);
        end
        chk(n_done == int'(edone), "R6", "done pulses", n_done, edone);
        chk(busy == 1'b0, "R6", "idle at end", busy, 0);
        chk(adma_err == eerr, "R7", "error flag", adma_err, eerr);
        if (eerr) chk(err_addr == eaddr, "R7", "error address", err_addr, eaddr);
        chk(n_overlap == 0, "R5", "read during move", n_overlap, 0);
        chk(n_unstable == 0, "R11", "move request held", n_unstable, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !adma_err && !rd_req && !mv_req, "R1", "reset outputs",
            {busy, done, adma_err, rd_req, mv_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: chain length, invalid position (n = none), latencies
        for (int n = 1; n <= 6; n++) begin
            for (int b = 0; b <= n; b++) begin
                int off;
                off = (n + b) % 9;
                for (int k = 0; k < 64; k++) mem[k] = '0;
                for (int i = 0; i < n; i++) begin
                    logic [15:0] len;
                    logic [1:0]  act;
                    len = ((i * 5 + n * 3) % 7 == 0) ? 16'h0 : 16'((i + 1) * 771 + n * 13 + b);
                    act = ((i + 2 * n + b) % 5 == 4) ? 2'b00 : 2'b10;
                    mem[off + i] = mk(i != b, i == n - 1, act, len,
                                      32'h2000_0000 + 32'(i) * 32'h1_0000 + 32'(n * 256));
                end
                rd_lat = 1 + (n + b) % 3;
                mv_lat = (n * 2 + b) % 4;
                run_chain(32'h8000_0000 + 32'(off * 8), -1, "R8");
            end
        end

        // largest explicit count
        for (int k = 0; k < 64; k++) mem[k] = '0;
        mem[3] = mk(1, 1, 2'b10, 16'hFFFF, 32'hCAFE_0000);
        rd_lat = 2; mv_lat = 1;
        run_chain(32'h8000_0018, -1, "R3");

        // start while busy is ignored (R9)
        for (int k = 0; k < 64; k++) mem[k] = '0;
        for (int i = 0; i < 4; i++)
            mem[i] = mk(1, i == 3, 2'b10, 16'(100 + i), 32'h3000_0000 + 32'(i * 16));
        mem[40] = mk(1, 1, 2'b10, 16'h0042, 32'hDEAD_0000);
        rd_lat = 1; mv_lat = 5;
        run_chain(32'h8000_0000, 6, "R9");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule